// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Acknowledge Handshake

This block takes an asynchronous serial line that idles high and turns each incoming character into a parallel byte for the surrounding logic. A character is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The line is first brought into the clock domain by a short synchronizer chain. A free-running divider produces a sample tick several times per bit period, and all framing decisions are made on those ticks.

When the idle line falls, the receiver waits half a bit and looks again. If the line is still low the start is accepted; otherwise the event is dropped as noise. From that centre point it takes one sample per bit period, so every data bit and the stop bit are read near their middle instead of near an edge. A character whose stop sample is low is thrown away, and the receiver then waits for the line to return high before it looks for a new start.

An accepted byte is placed in an output register and a full flag is raised. The consumer pulses an acknowledge input to release it. If another character finishes while the flag is still up and no acknowledge is present, the new character is discarded, the stored byte is kept, and a one-cycle overrun pulse is raised.

Top module: `serial_rx_hs`

## Requirements
- R1: While the asynchronous reset input is low, `rx_full` and `rx_overrun` are 0 and `rx_data` is 0x00, regardless of the clock.
- R2: A character with a valid stop bit is delivered on `rx_data`, bit 0 of the byte taken from the first data bit after the start bit, and `rx_full` goes to 1 within one bit period after the stop bit begins.
- R3: Once set, `rx_full` stays 1 while `rx_ack` is low, and goes to 0 on the clock edge after `rx_ack` is seen high (unless a new byte completes in that same cycle).
- R4: A character whose stop bit is low is not delivered: `rx_full` stays 0 and `rx_data` is unchanged.
- R5: A low pulse on the idle line shorter than half a bit period does not start a character: no byte is delivered and a following valid character is received correctly.
- R6: If a character completes while `rx_full` is 1 and `rx_ack` is low, `rx_overrun` is high for exactly one cycle, the new byte is discarded and `rx_data` keeps the earlier byte.
- R7: If a character completes in a cycle where `rx_ack` is high, the new byte is stored, `rx_full` is 1 on the next cycle and no overrun is reported.
- R8: Two characters sent with no idle time between the stop bit of the first and the start bit of the second are both received.
- R9: After a character with a low stop bit, a line held low produces no further bytes until it has gone high; the next valid character after that is received.
- R10: The sample tick is a single-cycle pulse repeating every `TICK_DIV` clocks, and one bit period lasts `OVERSAMPLE` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| rx_ack | input | 1 | Consumer acknowledge; high for a cycle releases the held byte |
| rx_data | output | 8 | Last accepted byte |
| rx_full | output | 1 | A byte is held and not yet acknowledged |
| rx_overrun | output | 1 | One-cycle pulse when a completed byte is dropped because the holder was full |

## Verification
The two events that can share a cycle are the completion of a character and the consumer's acknowledge. The bench provokes the meeting by holding `rx_ack` high across the whole arrival of a character and of two back-to-back characters, so the completion cycle is guaranteed to coincide with an acknowledge whatever the tick phase. It judges the result at the ports: every completion must show up as a one-cycle rise of `rx_full` carrying the new byte, and the overrun pulse counter must not move; the opposite case, completion with no acknowledge while full, must move that counter by exactly one and leave the old byte in place.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;

  // Tick index (counted from 0) at which the start bit is re-checked.
  function automatic int unsigned centre_tick(input int unsigned os);
    return os / 2 - 1;
  endfunction

  // Tick index at which one full bit period has elapsed.
  function automatic int unsigned period_tick(input int unsigned os);
    return os - 1;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick
  import serial_rx_pkg::*;
#(
  parameter int unsigned TICK_DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = cnt_width(TICK_DIV);
  localparam logic [CW-1:0] WRAP = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == WRAP);
      div_q  <= (div_q == WRAP) ? '0 : div_q + 1'b1;
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_gap
      a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o
);

  localparam int unsigned TW = cnt_width(OVERSAMPLE);
  localparam int unsigned BW = cnt_width(DATA_BITS);
  localparam logic [TW-1:0] MID_T  = TW'(centre_tick(OVERSAMPLE));
  localparam logic [TW-1:0] FULL_T = TW'(period_tick(OVERSAMPLE));
  localparam logic [BW-1:0] LAST_B = BW'(DATA_BITS - 1);

  rx_state_t            state_q;
  logic [TW-1:0]        tcnt_q;
  logic [BW-1:0]        bidx_q;
  logic [DATA_BITS-1:0] shift_q;

  // named events for the checks
  logic at_centre, at_period;
  assign at_centre = tick_i && (tcnt_q == MID_T);
  assign at_period = tick_i && (tcnt_q == FULL_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shift_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!line_i) begin
              state_q <= RX_START;
              tcnt_q  <= '0;
            end
          end
          RX_START: begin
            if (tcnt_q == MID_T) begin
              tcnt_q <= '0;
              bidx_q <= '0;
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt_q == FULL_T) begin
              tcnt_q  <= '0;
              shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
              if (bidx_q == LAST_B) state_q <= RX_STOP;
              else                  bidx_q  <= bidx_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (tcnt_q == FULL_T) begin
              tcnt_q <= '0;
              if (line_i) begin
                done_o  <= 1'b1;
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_WAIT_HIGH;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_WAIT_HIGH: begin
            if (line_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = shift_q;

  // R4: a byte is only reported when the stop sample was high
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(line_i) && $past(at_period));

  // R8: completion is a single-cycle event
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: a start that is high at its centre check returns to idle
  a_r5_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START) && at_centre && line_i |=> state_q == RX_IDLE);

  // R9: after a bad stop nothing restarts while the line stays low
  a_r9_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAIT_HIGH) && !line_i |=> state_q == RX_WAIT_HIGH);

endmodule

// File: rtl/serial_rx_hs.sv
module serial_rx_hs
  import serial_rx_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 2500,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned SYNC_FF    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       rx_ack,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       rx_overrun
);

  localparam int unsigned DATA_BITS = 8;

  logic                 line_s;
  logic                 tick;
  logic                 byte_done;
  logic [DATA_BITS-1:0] byte_new;

  serial_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_line),
    .q_o   (line_s)
  );

  serial_rx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  serial_rx_framer #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS)
  ) u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .line_i (line_s),
    .done_o (byte_done),
    .byte_o (byte_new)
  );

  // named handshake events
  logic take_byte, drop_byte;
  assign take_byte = byte_done && (!rx_full || rx_ack);
  assign drop_byte = byte_done && rx_full && !rx_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_overrun <= drop_byte;
      if (take_byte) begin
        rx_data <= byte_new;
        rx_full <= 1'b1;
      end else if (rx_ack) begin
        rx_full <= 1'b0;
      end
    end
  end

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rx_ack |=> rx_full);

  a_r3_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_ack && !byte_done |=> !rx_full);

  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_full) && !$past(rx_ack) && $past(byte_done));

  a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rx_ack |=> $stable(rx_data));

  a_r7_ack_meets_done: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_ack |=> rx_full && !rx_overrun);

endmodule

// File: tb/serial_rx_hs_tb.sv
module serial_rx_hs_tb;

  localparam int unsigned TDIV = 4;
  localparam int unsigned OS   = 16;
  localparam int unsigned BITC = TDIV * OS;   // clocks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rx_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       rx_overrun;

  int checks = 0;
  int fails  = 0;
  int ovr_cnt = 0;
  int cap_cnt = 0;
  logic [7:0] caps [0:63];
  logic prev_full = 1'b0;

  always #5 clk = ~clk;

  serial_rx_hs #(.TICK_DIV(TDIV), .OVERSAMPLE(OS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .rx_ack     (rx_ack),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun)
  );

  // port monitor: count overrun pulses, capture byte at each rise of full
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_overrun) ovr_cnt++;
      if (rx_full && !prev_full && cap_cnt < 64) begin
        caps[cap_cnt] = rx_data;
        cap_cnt++;
      end
      prev_full = rx_full;
    end else begin
      prev_full = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rx_line = 1'b0;
    wait_clk(BITC);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      wait_clk(BITC);
    end
    rx_line = stop;
    wait_clk(BITC);
    rx_line = 1'b1;
  endtask

  task automatic ack_pulse();
    rx_ack = 1'b1;
    wait_clk(1);
    rx_ack = 1'b0;
  endtask

  // {deliver expected, stop bit, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b1, 8'h55},
    {1'b1, 1'b1, 8'hA3},
    {1'b1, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h81},
    {1'b1, 1'b1, 8'hFF},
    {1'b1, 1'b1, 8'h6E}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int base_ovr, base_cap;
    held = 8'h00;

    // R1: reset state
    wait_clk(3);
    check(rx_full == 1'b0, "R1 full in reset", rx_full, 0);
    check(rx_data == 8'h00, "R1 data in reset", rx_data, 0);
    check(rx_overrun == 1'b0, "R1 overrun in reset", rx_overrun, 0);
    rst_n = 1'b1;
    wait_clk(2 * BITC);

    // table walk: R2 delivery, R3 hold/release, R4 bad stop
    for (int k = 0; k < 6; k++) begin
      base_ovr = ovr_cnt;
      send_frame(VEC[k][7:0], VEC[k][8]);
      wait_clk(16);
      if (VEC[k][9]) begin
        check(rx_full == 1'b1, "R2 full after frame", rx_full, 1);
        check(rx_data == VEC[k][7:0], "R2 byte value lsb first", rx_data, VEC[k][7:0]);
        wait_clk(100);
        check(rx_full == 1'b1, "R3 full held without ack", rx_full, 1);
        held = VEC[k][7:0];
        ack_pulse();
        check(rx_full == 1'b0, "R3 full cleared after ack", rx_full, 0);
      end else begin
        check(rx_full == 1'b0, "R4 bad stop not delivered", rx_full, 0);
        check(rx_data == held, "R4 data unchanged", rx_data, held);
      end
      check(ovr_cnt == base_ovr, "R6 no spurious overrun", ovr_cnt, base_ovr);
      wait_clk(BITC);
    end

    // R5: short glitch ignored, then a valid frame
    base_cap = cap_cnt;
    rx_line = 1'b0;
    wait_clk(BITC / 4);
    rx_line = 1'b1;
    wait_clk(3 * BITC);
    check(cap_cnt == base_cap && !rx_full, "R5 glitch produced no byte", cap_cnt, base_cap);
    send_frame(8'hC5, 1'b1);
    wait_clk(16);
    check(rx_full && rx_data == 8'hC5, "R5 frame after glitch", rx_data, 8'hC5);
    ack_pulse();
    wait_clk(BITC);

    // R9: bad stop followed by a long low line
    base_cap = cap_cnt;
    rx_line = 1'b0;
    wait_clk(20 * BITC);
    check(cap_cnt == base_cap && !rx_full, "R9 held low gives no byte", cap_cnt, base_cap);
    rx_line = 1'b1;
    wait_clk(BITC);
    send_frame(8'h3C, 1'b1);
    wait_clk(16);
    check(rx_full && rx_data == 8'h3C, "R9 frame after line high", rx_data, 8'h3C);
    ack_pulse();
    wait_clk(BITC);

    // R6: overrun when full and no ack
    base_ovr = ovr_cnt;
    send_frame(8'h12, 1'b1);
    wait_clk(16);
    send_frame(8'h34, 1'b1);
    wait_clk(16);
    check(ovr_cnt == base_ovr + 1, "R6 one overrun pulse", ovr_cnt, base_ovr + 1);
    check(rx_data == 8'h12, "R6 earlier byte kept", rx_data, 8'h12);
    check(rx_full == 1'b1, "R6 still full", rx_full, 1);
    ack_pulse();
    wait_clk(BITC);

    // R7 + R8: ack held across completion, two frames back to back
    base_ovr = ovr_cnt;
    base_cap = cap_cnt;
    rx_ack = 1'b1;
    send_frame(8'h9A, 1'b1);
    send_frame(8'h5B, 1'b1);
    wait_clk(16);
    rx_ack = 1'b0;
    wait_clk(2);
    check(cap_cnt == base_cap + 2, "R8 two back-to-back bytes", cap_cnt, base_cap + 2);
    check(caps[base_cap] == 8'h9A, "R7 first byte taken with ack", caps[base_cap], 8'h9A);
    check(caps[base_cap + 1] == 8'h5B, "R8 second byte", caps[base_cap + 1], 8'h5B);
    check(ovr_cnt == base_ovr, "R7 no overrun with ack", ovr_cnt, base_ovr);
    check(rx_full == 1'b0, "R7 released by held ack", rx_full, 0);

    // R1: asynchronous reset clears a held byte
    send_frame(8'hE7, 1'b1);
    wait_clk(16);
    check(rx_full && rx_data == 8'hE7, "R2 byte before reset", rx_data, 8'hE7);
    #2 rst_n = 1'b0;
    #1;
    check(rx_full == 1'b0, "R1 async reset clears full", rx_full, 0);
    check(rx_data == 8'h00, "R1 async reset clears data", rx_data, 0);
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule